// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the 32-bit program counter of a single-issue core and works out, every cycle, the address it will hold after the next rising clock edge. The current counter value goes straight out as the instruction-fetch address. A second output carries that value plus one instruction width (4 bytes), ready for a future link-register write.

On an enabled edge the counter takes one of three values. The first is the sequential address. The second is a relative branch target: the incremented address plus a sign-extended 16-bit offset counted in instructions. The third is an absolute jump target: the top four bits of the incremented address, then a 26-bit instruction field, then two zero bits. The branch path needs two conditions at once. The decoder's branch flag must be set and the comparator's equality result must be true.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level-sampled control or address signal. The surrounding pipeline holds the counter by dropping `advance`. No back-pressure interface exists beyond that.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_addr` becomes 0x00000000 after that edge, whatever the other inputs are, including `advance` low.
- R2: `pc_inc` always equals `pc_addr` + 4 modulo 2^32, and both outputs change only just after a rising edge.
- R3: With `advance` high, `jump_sel` low, and not both `branch_sel` and `cmp_equal` high, `pc_addr` becomes the old `pc_addr` + 4.
- R4: With `advance` high, `jump_sel` low, and both `branch_sel` and `cmp_equal` high, `pc_addr` becomes old `pc_addr` + 4 + (sign-extended `br_offset` × 4). Bit 15 of `br_offset` is the sign bit.
- R5: `branch_sel` high with `cmp_equal` low, or `cmp_equal` high with `branch_sel` low, gives the sequential address of R3.
- R6: With `advance` and `jump_sel` high, `pc_addr` becomes {bits 31..28 of old `pc_addr` + 4, `jump_field`[25:0], 2'b00}.
- R7: When `jump_sel` is high, the jump target of R6 is loaded even if `branch_sel` and `cmp_equal` are both high. The priority order is jump, then branch, then sequential.
- R8: With `rst` low and `advance` low, `pc_addr` keeps its value across the edge, whatever `jump_sel`, `branch_sel`, `cmp_equal`, `br_offset` and `jump_field` are.
- R9: All address sums wrap modulo 2^32 with no flag. 0xFFFFFFFC steps to 0x00000000, and a negative offset from a low address wraps to the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Update enable; low holds the counter |
| jump_sel | input | 1 | Select the absolute jump target |
| branch_sel | input | 1 | Instruction is a conditional branch |
| cmp_equal | input | 1 | Equality result of the two compared registers |
| br_offset | input | 16 | Signed branch offset in instruction units |
| jump_field | input | 26 | Jump target field in instruction units |
| pc_addr | output | 32 | Current program counter, the fetch address |
| pc_inc | output | 32 | Current program counter plus 4 |

## Verification
The counter register is the only state, so every select, offset and enable takes effect in `pc_addr` exactly one rising edge after it is applied. `pc_inc` follows from the new `pc_addr` with no extra cycle. The bench applies inputs at the falling edge. A behavioural model advances on the rising edge. Both outputs are compared at the next falling edge, before new inputs go in, so each comparison covers exactly one edge's decision. Directed steps cover reset while held, priority clashes, both branch half-conditions, region carry into the jump target, and wrap in both directions. A long run of random input patterns follows them.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  // Which candidate address the counter loads on an enabled edge
  typedef enum logic [1:0] {
    SRC_SEQ    = 2'd0,
    SRC_BRANCH = 2'd1,
    SRC_JUMP   = 2'd2
  } pc_src_e;

  // Fixed priority: jump over taken branch over sequential
  function automatic pc_src_e pick_source(input logic jump_sel,
                                          input logic branch_sel,
                                          input logic cmp_equal);
    if (jump_sel)                    return SRC_JUMP;
    else if (branch_sel && cmp_equal) return SRC_BRANCH;
    else                             return SRC_SEQ;
  endfunction

endpackage

// File: rtl/pcu_incr.sv
module pcu_incr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  // Modulo-2^ADDR_W sum; carry out is dropped on purpose
  assign addr_out = addr_in + STEP_V;
endmodule

// File: rtl/pcu_branch_tgt.sv
module pcu_branch_tgt #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  offset,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - IMM_W - SHIFT;

  logic [ADDR_W-1:0] byte_off;

  generate
    if (SHIFT > 0) begin : g_scaled
      assign byte_off = {{EXT_W{offset[IMM_W-1]}}, offset, {SHIFT{1'b0}}};
    end else begin : g_unscaled
      assign byte_off = {{EXT_W{offset[IMM_W-1]}}, offset};
    end
  endgenerate

  assign target = base + byte_off;
endmodule

// File: rtl/pcu_jump_tgt.sv
module pcu_jump_tgt #(
  parameter int ADDR_W = 32,
  parameter int FLD_W  = 26,
  parameter int SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [FLD_W-1:0]  field,
  output logic [ADDR_W-1:0] target
);
  localparam int REGION_W = ADDR_W - FLD_W - SHIFT;

  logic [REGION_W-1:0] region;
  assign region = base[ADDR_W-1 -: REGION_W];

  generate
    if (SHIFT > 0) begin : g_scaled
      assign target = {region, field, {SHIFT{1'b0}}};
    end else begin : g_unscaled
      assign target = {region, field};
    end
  endgenerate
endmodule

// File: rtl/pcu_src_mux.sv
module pcu_src_mux
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              jump_sel,
  input  logic              branch_sel,
  input  logic              cmp_equal,
  input  logic [ADDR_W-1:0] seq_addr,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic [ADDR_W-1:0] jmp_addr,
  output logic [ADDR_W-1:0] next_addr
);
  pc_src_e src;

  always_comb begin
    src = pick_source(jump_sel, branch_sel, cmp_equal);
    unique case (src)
      SRC_JUMP:   next_addr = jmp_addr;
      SRC_BRANCH: next_addr = br_addr;
      default:    next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int          ADDR_W      = 32,
  parameter int          IMM_W       = 16,
  parameter int          JFLD_W      = 26,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_PC    = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              jump_sel,
  input  logic              branch_sel,
  input  logic              cmp_equal,
  input  logic [IMM_W-1:0]  br_offset,
  input  logic [JFLD_W-1:0] jump_field,
  output logic [ADDR_W-1:0] pc_addr,
  output logic [ADDR_W-1:0] pc_inc
);
  localparam int SHIFT = $clog2(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] RESET_V = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] br_addr;
  logic [ADDR_W-1:0] jmp_addr;
  logic [ADDR_W-1:0] next_addr;

  pcu_incr #(.ADDR_W(ADDR_W), .STEP(INSTR_BYTES)) u_incr (
    .addr_in  (pc_q),
    .addr_out (seq_addr)
  );

  pcu_branch_tgt #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_br (
    .base   (seq_addr),
    .offset (br_offset),
    .target (br_addr)
  );

  pcu_jump_tgt #(.ADDR_W(ADDR_W), .FLD_W(JFLD_W), .SHIFT(SHIFT)) u_jmp (
    .base   (seq_addr),
    .field  (jump_field),
    .target (jmp_addr)
  );

  pcu_src_mux #(.ADDR_W(ADDR_W)) u_mux (
    .jump_sel   (jump_sel),
    .branch_sel (branch_sel),
    .cmp_equal  (cmp_equal),
    .seq_addr   (seq_addr),
    .br_addr    (br_addr),
    .jmp_addr   (jmp_addr),
    .next_addr  (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= RESET_V;
    else if (advance) pc_q <= next_addr;
  end

  assign pc_addr = pc_q;
  assign pc_inc  = seq_addr;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int          ADDR_W      = 32,
  parameter int          IMM_W       = 16,
  parameter int          JFLD_W      = 26,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_PC    = 32'h0000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              advance,
  input logic              jump_sel,
  input logic              branch_sel,
  input logic              cmp_equal,
  input logic [IMM_W-1:0]  br_offset,
  input logic [JFLD_W-1:0] jump_field,
  input logic [ADDR_W-1:0] pc_addr,
  input logic [ADDR_W-1:0] pc_inc
);
  localparam int SHIFT    = $clog2(INSTR_BYTES);
  localparam int REGION_W = ADDR_W - JFLD_W - SHIFT;
  localparam logic [ADDR_W-1:0] LOW_MASK = {ADDR_W{1'b1}} >> REGION_W;
  localparam logic [ADDR_W-1:0] WIDTH_V  = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] off_bytes;
  logic [ADDR_W-1:0] jmp_expect;
  assign off_bytes  = ADDR_W'($signed(br_offset)) << SHIFT;
  assign jmp_expect = (pc_inc & ~LOW_MASK) | (ADDR_W'(jump_field) << SHIFT);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> pc_addr == ADDR_W'(RESET_PC));

  assert_inc_R2: assert property (@(posedge clk) disable iff (rst)
    pc_inc == pc_addr + WIDTH_V);

  assert_seq_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !jump_sel && !(branch_sel && cmp_equal))
      |=> pc_addr == $past(pc_addr) + WIDTH_V);

  assert_branch_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && !jump_sel && branch_sel && cmp_equal)
      |=> pc_addr == $past(pc_inc) + $past(off_bytes));

  assert_jump_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && jump_sel) |=> pc_addr == $past(jmp_expect));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pc_addr));
endmodule

bind pc_next_unit pcu_checker #(
  .ADDR_W(ADDR_W), .IMM_W(IMM_W), .JFLD_W(JFLD_W),
  .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)
) u_pcu_checker (
  .clk        (clk),
  .rst        (rst),
  .advance    (advance),
  .jump_sel   (jump_sel),
  .branch_sel (branch_sel),
  .cmp_equal  (cmp_equal),
  .br_offset  (br_offset),
  .jump_field (jump_field),
  .pc_addr    (pc_addr),
  .pc_inc     (pc_inc)
);

// File: tb/test_pc_next_unit.sv
module test_pc_next_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic        jump_sel = 1'b0;
  logic        branch_sel = 1'b0;
  logic        cmp_equal = 1'b0;
  logic [15:0] br_offset = '0;
  logic [25:0] jump_field = '0;
  logic [31:0] pc_addr;
  logic [31:0] pc_inc;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_next_unit i_pc_next_unit (
    .clk(clk), .rst(rst), .advance(advance), .jump_sel(jump_sel),
    .branch_sel(branch_sel), .cmp_equal(cmp_equal), .br_offset(br_offset),
    .jump_field(jump_field), .pc_addr(pc_addr), .pc_inc(pc_inc)
  );

  function automatic logic [31:0] model_next(logic [31:0] cur, logic r, logic a,
      logic j, logic b, logic e, logic [15:0] off, logic [25:0] fld);
    logic [31:0] nxt4;
    nxt4 = cur + 32'd4;
    if (r)           return 32'h0;
    else if (!a)     return cur;
    else if (j)      return {nxt4[31:28], fld, 2'b00};
    else if (b && e) return nxt4 + {{14{off[15]}}, off, 2'b00};
    else             return nxt4;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic r, logic a, logic j, logic b, logic e,
                      logic [15:0] off, logic [25:0] fld, string tag_in);
    string tag;
    rst = r; advance = a; jump_sel = j; branch_sel = b; cmp_equal = e;
    br_offset = off; jump_field = fld;
    if (tag_in != "")    tag = tag_in;
    else if (r)          tag = "R1";
    else if (!a)         tag = "R8";
    else if (j && b && e) tag = "R7";
    else if (j)          tag = "R6";
    else if (b && e)     tag = "R4";
    else if (b || e)     tag = "R5";
    else                 tag = "R3";
    @(posedge clk);
    m_pc = model_next(m_pc, r, a, j, b, e, off, fld);
    @(negedge clk);
    check(tag, "pc_addr", pc_addr, m_pc);
    check("R2", "pc_inc", pc_inc, m_pc + 32'd4);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, also with advance low
    step(1, 0, 1, 1, 1, 16'h7FFF, 26'h3FFFFFF, "R1");
    step(1, 1, 0, 0, 0, 16'h0, 26'h0, "R1");
    // R3: plain increments
    step(0, 1, 0, 0, 0, 16'h0, 26'h0, "");
    step(0, 1, 0, 0, 0, 16'h1234, 26'h0, "");
    // R5: half conditions do not branch
    step(0, 1, 0, 1, 0, 16'h0010, 26'h0, "");
    step(0, 1, 0, 0, 1, 16'h0010, 26'h0, "");
    // R4: forward and backward branch
    step(0, 1, 0, 1, 1, 16'h0010, 26'h0, "");
    step(0, 1, 0, 1, 1, 16'hFFFC, 26'h0, "");
    // R8: hold with every select set
    step(0, 0, 1, 1, 1, 16'h00FF, 26'h155, "");
    step(0, 0, 0, 1, 1, 16'h0001, 26'h0, "");
    // R6 and R7: jump, and jump beating a taken branch
    step(0, 1, 1, 0, 0, 16'h0, 26'h0ABCDE, "");
    step(0, 1, 1, 1, 1, 16'h0040, 26'h0000010, "");
    // R9: wrap below zero, then wrap above the top
    step(1, 1, 0, 0, 0, 16'h0, 26'h0, "R1");
    step(0, 1, 0, 1, 1, 16'hFFFE, 26'h0, "R9");  // 4 - 8 -> FFFFFFFC
    step(0, 1, 0, 0, 0, 16'h0, 26'h0, "R9");     // -> 00000000
    step(0, 1, 0, 1, 1, 16'hFFFD, 26'h0, "R9");  // 4 - 12 -> FFFFFFF8
    // R6: region bits come from pc+4 (FFFFFFFC) -> F000048C
    step(0, 1, 1, 0, 0, 16'h0, 26'h0000123, "R6");
    step(0, 1, 1, 0, 0, 16'h0, 26'h3FFFFFF, "R6");
    // random patterns
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      step(rv[4:0] == 5'd0, rv[7:5] != 3'd0, rv[10:8] == 3'd0,
           rv[11], rv[12], 16'($urandom), 26'($urandom), "");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule